// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit count register with a 16-bit capture/reload register beside it. It runs in one of three modes. In capture mode it counts freely and takes snapshots on an external trigger. In auto-reload mode it counts up, or up and down under pin control, and restarts from a programmed value. In baud mode it produces a pulse on each overflow, which a serial port uses as its bit clock. Counting is paced by a machine-cycle enable (`mc_tick`). Each count step is either one machine cycle (timer function) or one falling edge seen on the count pin between two consecutive machine-cycle samples (counter function).

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The block has no streaming data path, so every pin is plain control or status with no handshake. Two sticky flags, a combined interrupt request and the baud pulse are brought out as pins.

Top module: `mmtimer16`

## Requirements
- R1: After reset every register reads 0, and `irq`, `ovf_flag`, `ext_flag` and `baud_pulse` are low.
- R2: Register addresses are: 0 control, 1 mode, 2 count low byte, 3 count high byte, 4 reload low byte, 5 reload high byte. Addresses 6 and 7 read 0. Control bits, from 7 down to 0, are: overflow flag, external flag, receive-clock select, transmit-clock select, external enable, run, counter select, capture select. The mode register holds only bit 0 (down enable); its other bits read 0.
- R3: With run = 0 the count holds. With run = 1, either clock select gives baud mode. Otherwise capture select 1 gives capture mode and capture select 0 gives auto-reload mode.
- R4: With counter select 0 the count steps on every `mc_tick`. With counter select 1 it steps on an `mc_tick` where `cnt_pin` is low and was high at the previous `mc_tick`. A pin held at one level never counts.
- R5: In capture mode the count wraps from FFFFh to 0000h and sets the overflow flag. With external enable set, a trigger falling edge (sampled per `mc_tick` as in R4) copies the count value from before that step into the reload register and sets the external flag. With external enable clear, trigger edges have no effect.
- R6: In auto-reload mode with down enable 0, a step from FFFFh loads the reload value and sets the overflow flag. With external enable set, a trigger falling edge loads the reload value instead of stepping and sets the external flag.
- R7: In auto-reload mode with down enable 1, `trig_pin` high at a step counts up and low counts down. Counting down while the count equals the reload value loads FFFFh and sets the overflow flag. Trigger edges cause no reload and leave the external flag unchanged.
- R8: In baud mode an overflow loads the reload value and never sets the overflow flag. Capture select and trigger edges are ignored. `baud_pulse` is high for the one clock that follows the reloading edge.
- R9: Both flags stay set until a control write puts 0 in their bit. Writing 1 to a flag bit never sets it. A hardware event in the same cycle as a clearing write leaves the flag set.
- R10: `irq` is high when the overflow flag is set, or when the external flag is set and down enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle enable, one clock wide |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger / direction input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-clock overflow pulse in baud mode |

## Verification
The count path is driven under four input patterns, each of which separates cases that other patterns cannot:
- A steady machine-cycle enable shows the timer step and the exact cycle of the FFFFh rollover.
- A count pin that is toggled, and then held low or high across several ticks, separates real falling edges from static levels.
- A trigger pin toggled under capture, reload, down-enable and baud settings tells a snapshot from a reload from an edge that must be ignored.
- A trigger level held high or low while down enable is set shows the direction choice and the down-count reload at the reload value.

Flag writes with 0 and with 1 separate clearing from setting, and the interrupt is read with and without down enable to show the masking of the external flag.

// File: rtl/mmtimer16_pkg.sv
`timescale 1ns/1ps
package mmtimer16_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_MODE   = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT_LO = 3'd2;
  localparam logic [REG_AW-1:0] A_CNT_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_CAP_LO = 3'd4;
  localparam logic [REG_AW-1:0] A_CAP_HI = 3'd5;

  // control byte, bit 7 first
  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic cnt_sel;
    logic cap_sel;
  } ctrl_t;

  typedef enum logic [1:0] {
    M_OFF     = 2'd0,
    M_RELOAD  = 2'd1,
    M_CAPTURE = 2'd2,
    M_BAUD    = 2'd3
  } mode_e;
endpackage

// File: rtl/mmtimer16_sampler.sv
`timescale 1ns/1ps
module mmtimer16_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  // one sample per machine cycle; a fall is high-then-low across two samples
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic smp_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    smp_q <= 1'b0;
      else if (tick) smp_q <= pin[i];
    end
    assign fall[i] = tick & smp_q & ~pin[i];
  end
endmodule

// File: rtl/mmtimer16_decode.sv
`timescale 1ns/1ps
module mmtimer16_decode
  import mmtimer16_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  dcen,
  output mode_e mode,
  output logic  trig_ok
);
  always_comb begin
    if (!ctrl.run)                        mode = M_OFF;
    else if (ctrl.rx_sel || ctrl.tx_sel)  mode = M_BAUD;
    else if (ctrl.cap_sel)                mode = M_CAPTURE;
    else                                  mode = M_RELOAD;
  end

  assign trig_ok = ctrl.ext_en &
                   ((mode == M_CAPTURE) | ((mode == M_RELOAD) & ~dcen));
endmodule

// File: rtl/mmtimer16_core.sv
`timescale 1ns/1ps
module mmtimer16_core
  import mmtimer16_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              step,
  input  logic              dir_up,
  input  logic              trig_evt,
  input  logic              cnt_wr_lo,
  input  logic              cnt_wr_hi,
  input  logic              cap_wr_lo,
  input  logic              cap_wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [W-1:0]      cnt_q,
  output logic [W-1:0]      cap_q,
  output logic              ovf_evt,
  output logic              ext_evt,
  output logic              baud_evt
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_d, cap_d;
  logic         at_top, at_cap;

  assign at_top = (cnt_q == TOP);
  assign at_cap = (cnt_q == cap_q);

  always_comb begin
    cnt_d    = cnt_q;
    cap_d    = cap_q;
    ovf_evt  = 1'b0;
    ext_evt  = 1'b0;
    baud_evt = 1'b0;
    unique case (mode)
      M_CAPTURE: begin
        if (step) begin
          cnt_d   = cnt_q + 1'b1;
          ovf_evt = at_top;
        end
        if (trig_evt) begin
          cap_d   = cnt_q;
          ext_evt = 1'b1;
        end
      end
      M_RELOAD: begin
        if (trig_evt) begin
          cnt_d   = cap_q;
          ext_evt = 1'b1;
        end else if (step) begin
          if (dir_up) begin
            if (at_top) begin
              cnt_d   = cap_q;
              ovf_evt = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (at_cap) begin
              cnt_d   = TOP;
              ovf_evt = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
      end
      M_BAUD: begin
        if (step) begin
          if (at_top) begin
            cnt_d    = cap_q;
            baud_evt = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: ;
    endcase

    // a software write to either byte wins over hardware for that register
    if (cnt_wr_lo || cnt_wr_hi) begin
      cnt_d = cnt_q;
      if (cnt_wr_lo) cnt_d[HALF_W-1:0] = wdata;
      if (cnt_wr_hi) cnt_d[W-1:HALF_W] = wdata;
    end
    if (cap_wr_lo || cap_wr_hi) begin
      cap_d = cap_q;
      if (cap_wr_lo) cap_d[HALF_W-1:0] = wdata;
      if (cap_wr_hi) cap_d[W-1:HALF_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end
endmodule

// File: rtl/mmtimer16.sv
`timescale 1ns/1ps
module mmtimer16
  import mmtimer16_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              baud_pulse
);
  localparam int CNT_W = 2 * DATA_W;

  ctrl_t            ctrl_q;
  logic             dcen_q;
  logic             baud_q;
  mode_e            mode;
  logic             trig_ok;
  logic [1:0]       falls;
  logic             cnt_fall, trig_fall, trig_evt;
  logic             step, dir_up;
  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             ovf_evt, ext_evt, baud_evt;
  logic             wr_ctrl, wr_mode;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_mode = reg_wr && (reg_addr == A_MODE);

  mmtimer16_sampler #(.N(2)) u_smp (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (mc_tick),
    .pin  ({trig_pin, cnt_pin}),
    .fall (falls)
  );
  assign cnt_fall  = falls[0];
  assign trig_fall = falls[1];

  mmtimer16_decode u_dec (
    .ctrl   (ctrl_q),
    .dcen   (dcen_q),
    .mode   (mode),
    .trig_ok(trig_ok)
  );

  assign step     = mc_tick & (ctrl_q.cnt_sel ? cnt_fall : 1'b1);
  assign dir_up   = ~dcen_q | trig_pin;
  assign trig_evt = trig_fall & trig_ok;

  mmtimer16_core #(.HALF_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .step     (step),
    .dir_up   (dir_up),
    .trig_evt (trig_evt),
    .cnt_wr_lo(reg_wr && (reg_addr == A_CNT_LO)),
    .cnt_wr_hi(reg_wr && (reg_addr == A_CNT_HI)),
    .cap_wr_lo(reg_wr && (reg_addr == A_CAP_LO)),
    .cap_wr_hi(reg_wr && (reg_addr == A_CAP_HI)),
    .wdata    (reg_wdata),
    .cnt_q    (cnt_q),
    .cap_q    (cap_q),
    .ovf_evt  (ovf_evt),
    .ext_evt  (ext_evt),
    .baud_evt (baud_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dcen_q <= 1'b0;
      baud_q <= 1'b0;
    end else begin
      baud_q <= baud_evt;
      if (wr_ctrl) ctrl_q[5:0] <= reg_wdata[5:0];
      // flags: software may only clear; a same-cycle event keeps them set
      ctrl_q.ovf <= (ctrl_q.ovf & ~(wr_ctrl & ~reg_wdata[7])) | ovf_evt;
      ctrl_q.ext <= (ctrl_q.ext & ~(wr_ctrl & ~reg_wdata[6])) | ext_evt;
      if (wr_mode) dcen_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:   reg_rdata[7:0] = ctrl_q;
      A_MODE:   reg_rdata[0]   = dcen_q;
      A_CNT_LO: reg_rdata      = cnt_q[DATA_W-1:0];
      A_CNT_HI: reg_rdata      = cnt_q[CNT_W-1:DATA_W];
      A_CAP_LO: reg_rdata      = cap_q[DATA_W-1:0];
      A_CAP_HI: reg_rdata      = cap_q[CNT_W-1:DATA_W];
      default:  reg_rdata      = '0;
    endcase
  end

  assign ovf_flag   = ctrl_q.ovf;
  assign ext_flag   = ctrl_q.ext;
  assign irq        = ctrl_q.ovf | (ctrl_q.ext & ~dcen_q);
  assign baud_pulse = baud_q;
endmodule

// File: rtl/mmtimer16_sva.sv
`timescale 1ns/1ps
module mmtimer16_sva
  import mmtimer16_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input ctrl_t             ctrl_q,
  input logic              dcen_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cap_q,
  input logic              trig_evt,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ovf_flag,
  input logic              irq,
  input logic              baud_pulse
);
  logic cnt_wr, cap_wr, clksel;
  assign cnt_wr = reg_wr && (reg_addr == A_CNT_LO || reg_addr == A_CNT_HI);
  assign cap_wr = reg_wr && (reg_addr == A_CAP_LO || reg_addr == A_CAP_HI);
  assign clksel = ctrl_q.rx_sel | ctrl_q.tx_sel;

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !cnt_wr) |=> $stable(cnt_q));

  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && ctrl_q.cap_sel && !clksel && !cap_wr) |=> (cap_q == $past(cnt_q)));

  a_r8_no_ovf_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
    (clksel && !ovf_flag) |=> !ovf_flag);

  a_r8_pulse_only_baud: assert property (@(posedge clk) disable iff (!rst_n)
    baud_pulse |-> $past(ctrl_q.run && clksel));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(reg_wr && reg_addr == A_CTRL && !reg_wdata[7])) |=> ovf_flag);

  a_r10_ext_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (dcen_q && !ovf_flag) |-> !irq);
endmodule

bind mmtimer16 mmtimer16_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .dcen_q    (dcen_q),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q),
  .trig_evt  (trig_evt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .baud_pulse(baud_pulse)
);

// File: tb/sim_mmtimer16.sv
`timescale 1ns/1ps
module sim_mmtimer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic       cnt_pin = 1'b0;
  logic       trig_pin = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ovf_flag, ext_flag, irq, baud_pulse;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  typedef struct {
    string      req;
    int         sel;   // 0 read data, 1 irq, 2 baud_pulse
    logic [7:0] exp;
  } item_t;
  item_t exp_q[$];
  event  chk_ev;

  mmtimer16 #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .irq(irq), .baud_pulse(baud_pulse)
  );

  always #2.5 clk = ~clk;

  // monitor: pops each expected item and compares it with what the design shows
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = exp_q.pop_front();
        case (it.sel)
          1:       act = {7'd0, irq};
          2:       act = {7'd0, baud_pulse};
          default: act = reg_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver tasks: each starts and ends at a falling clock edge
  task automatic push_chk(string req, int sel, logic [2:0] a, logic [7:0] exp);
    item_t it;
    reg_addr = a;
    #0.5;
    it.req = req; it.sel = sel; it.exp = exp;
    exp_q.push_back(it);
    -> chk_ev;
    #0.5;
    @(negedge clk);
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [7:0] exp);
    push_chk(req, 0, a, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    mc_tick = 1'b1;
    repeat (n) @(negedge clk);
    mc_tick = 1'b0;
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic set_cap(logic [15:0] v);
    wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) chk_reg("R1", 3'(a), 8'h00);
    push_chk("R1 irq", 1, 3'd0, 8'h00);
    push_chk("R1 baud", 2, 3'd0, 8'h00);
    chk_reg("R2 unused addr", 3'd6, 8'h00);

    // R6 / R4 timer up-count and rollover reload
    set_cap(16'hFFFD); set_cnt(16'hFFFE); wr(3'd0, 8'h04);
    chk_reg("R2 reload lo readback", 3'd4, 8'hFD);
    ticks(1);
    chk_reg("R4 timer step", 3'd2, 8'hFF);
    chk_reg("R6 no flag before rollover", 3'd0, 8'h04);
    ticks(1);
    chk_reg("R6 reload lo", 3'd2, 8'hFD);
    chk_reg("R6 reload hi", 3'd3, 8'hFF);
    chk_reg("R6 overflow flag", 3'd0, 8'h84);
    push_chk("R10 irq from overflow", 1, 3'd0, 8'h01);

    // R9 flag write semantics
    wr(3'd0, 8'h84);
    chk_reg("R9 write 1 keeps flag", 3'd0, 8'h84);
    wr(3'd0, 8'h04);
    chk_reg("R9 write 0 clears", 3'd0, 8'h04);
    push_chk("R10 irq low after clear", 1, 3'd0, 8'h00);
    wr(3'd0, 8'h84);
    chk_reg("R9 write 1 does not set", 3'd0, 8'h04);

    // R3 stopped counter holds; R2 mode register width
    wr(3'd0, 8'h00);
    ticks(5);
    chk_reg("R3 hold when stopped", 3'd2, 8'hFD);
    wr(3'd1, 8'hFF);
    chk_reg("R2 mode reg bit0 only", 3'd1, 8'h01);
    wr(3'd1, 8'h00);

    // R4 counter function
    set_cnt(16'h0000); wr(3'd0, 8'h06);
    cnt_pin = 1'b1; ticks(1);
    chk_reg("R4 high sample no count", 3'd2, 8'h00);
    cnt_pin = 1'b0; ticks(1);
    chk_reg("R4 fall counts", 3'd2, 8'h01);
    ticks(2);
    chk_reg("R4 held low no count", 3'd2, 8'h01);
    cnt_pin = 1'b1; ticks(3);
    chk_reg("R4 held high no count", 3'd2, 8'h01);
    cnt_pin = 1'b0; ticks(1);
    chk_reg("R4 second fall", 3'd2, 8'h02);

    // R6 trigger reload
    wr(3'd0, 8'h0C); set_cap(16'h1234); set_cnt(16'h0100);
    trig_pin = 1'b1; ticks(1);
    chk_reg("R6 step before trigger", 3'd2, 8'h01);
    trig_pin = 1'b0; ticks(1);
    chk_reg("R6 trigger reload lo", 3'd2, 8'h34);
    chk_reg("R6 trigger reload hi", 3'd3, 8'h12);
    chk_reg("R6 ext flag", 3'd0, 8'h4C);
    push_chk("R10 irq from ext", 1, 3'd0, 8'h01);

    // R10 masking of ext flag by down enable
    wr(3'd1, 8'h01);
    push_chk("R10 ext masked", 1, 3'd0, 8'h00);
    wr(3'd1, 8'h00);
    push_chk("R10 ext unmasked", 1, 3'd0, 8'h01);
    wr(3'd0, 8'h00);
    chk_reg("R9 both flags cleared", 3'd0, 8'h00);

    // R5 capture
    set_cnt(16'h0200); wr(3'd0, 8'h0D);
    trig_pin = 1'b1; ticks(1);
    trig_pin = 1'b0; ticks(1);
    chk_reg("R5 capture lo", 3'd4, 8'h01);
    chk_reg("R5 capture hi", 3'd5, 8'h02);
    chk_reg("R5 count keeps running", 3'd2, 8'h02);
    chk_reg("R5 ext flag", 3'd0, 8'h4D);
    wr(3'd0, 8'h0D); set_cnt(16'hFFFF);
    ticks(1);
    chk_reg("R5 wrap lo", 3'd2, 8'h00);
    chk_reg("R5 wrap hi", 3'd3, 8'h00);
    chk_reg("R5 wrap flag", 3'd0, 8'h8D);
    wr(3'd0, 8'h05);
    trig_pin = 1'b1; ticks(1);
    trig_pin = 1'b0; ticks(1);
    chk_reg("R5 no capture without enable", 3'd4, 8'h01);
    chk_reg("R5 no ext without enable", 3'd0, 8'h05);

    // R7 down counting
    wr(3'd1, 8'h01); wr(3'd0, 8'h04); set_cap(16'h0010); set_cnt(16'h0012);
    ticks(3);
    chk_reg("R7 down reload lo", 3'd2, 8'hFF);
    chk_reg("R7 down reload hi", 3'd3, 8'hFF);
    chk_reg("R7 down overflow flag", 3'd0, 8'h84);
    trig_pin = 1'b1; ticks(1);
    chk_reg("R7 up rollover to reload", 3'd2, 8'h10);
    wr(3'd0, 8'h0C); set_cnt(16'h0050);
    ticks(1);
    chk_reg("R7 up step", 3'd2, 8'h51);
    trig_pin = 1'b0; ticks(1);
    chk_reg("R7 trigger fall only steps down", 3'd2, 8'h50);
    chk_reg("R7 no ext flag", 3'd0, 8'h0C);
    wr(3'd1, 8'h00);

    // R8 baud mode
    wr(3'd0, 8'h14); set_cap(16'hFFF0); set_cnt(16'hFFFE);
    ticks(2);
    push_chk("R8 baud pulse high", 2, 3'd2, 8'h01);
    push_chk("R8 baud pulse one clock", 2, 3'd2, 8'h00);
    chk_reg("R8 reload on overflow", 3'd2, 8'hF0);
    chk_reg("R8 no overflow flag", 3'd0, 8'h14);
    wr(3'd0, 8'h3D); set_cnt(16'hFFFF);
    trig_pin = 1'b1; ticks(1);
    trig_pin = 1'b0; ticks(1);
    chk_reg("R8 capture select ignored", 3'd2, 8'hF1);
    chk_reg("R8 trigger ignored", 3'd4, 8'hF0);
    chk_reg("R8 flags untouched", 3'd0, 8'h3D);

    wait (exp_q.size() == 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule